// File: doc/BRIEF.md
# Link-Down Report Timer

This block sits behind the receive side of a 1000BASE-T transceiver and decides when a loss of the raw link-ok indication becomes a reported link-down. In its default mode it holds the reported status up until the failure has lasted the full compliant interval of 750 ms. Fast failover is the other mode, and it does not comply with the standard. A single enable bit selects it, and a 2-bit select then picks a short hold time of 0, 10, 20 or 40 ms. This lets a metro network meet a 50 ms failover budget.

A prescaler turns the clock into a millisecond tick. Its division ratio is a parameter, so a testbench can shrink real time. The mode and the select are sampled once per failure, on the first clock edge that sees the raw indication low while the link is reported up. A glitch that ends before the hold time expires leaves the reported link up and rearms the timer. The block does not qualify link-up. The reported status follows a returning raw indication one edge later.

Top module: `link_down_timer`

## Requirements
- R1: While rst_ni is low, link_up_o is 0, and it goes to 0 as soon as reset is asserted, without waiting for a clock edge.
- R2: When link_up_o is 0 and a rising clk_i edge samples raw_link_ok_i high, link_up_o is 1 after that edge. While raw_link_ok_i stays high, link_up_o stays 1.
- R3: With fast_en_i = 0, a failure is reported only after 750 ms. With CLK_PER_MS clocks per millisecond, link_up_o falls on the edge STD_MS*CLK_PER_MS cycles after the first low sample. fast_sel_i has no effect in this mode.
- R4: With fast_en_i = 1, fast_sel_i sets the hold time: 2'b00 = 0 ms, 2'b01 = 10 ms, 2'b10 = 20 ms, 2'b11 = 40 ms. link_up_o falls exactly N*CLK_PER_MS edges after the first low sample, which lies inside the ±2 ms tolerance.
- R5: With fast_en_i = 1 and fast_sel_i = 2'b00, link_up_o falls on the same edge that first samples raw_link_ok_i low.
- R6: If raw_link_ok_i is sampled high before the hold time expires, link_up_o stays 1. The next failure starts a full new hold time.
- R7: fast_en_i and fast_sel_i are sampled only at the failure event. A change to them during a running hold time does not alter that hold time, and it applies to the next failure.
- R8: The millisecond tick is derived from the CLK_PER_MS parameter and counts only while a hold time is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_link_ok_i | input | 1 | Unqualified link-ok from the receiver |
| fast_en_i | input | 1 | 1 selects the short, non-compliant hold time |
| fast_sel_i | input | 2 | Short hold time select: 00 = 0 ms, 01 = 10 ms, 10 = 20 ms, 11 = 40 ms |
| link_up_o | output | 1 | Reported link status |

## Verification
A prescaler or millisecond counter that is off by one moves the falling edge of link_up_o by one cycle or by one full millisecond. This shows up only at the expiry edge, so each hold time is probed on both sides of its exact boundary. If the delay target is captured at the wrong time, a mid-count mode change shortens or lengthens the running hold time, and this appears within that same failure. A missed timer restart appears as a drop during the second of two short outages whose combined length exceeds the hold time.

// File: rtl/ldt_pkg.sv
package ldt_pkg;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned N_FAST = 1 << SEL_W;

  typedef enum logic [1:0] {
    RPT_DOWN = 2'd0,
    RPT_UP   = 2'd1,
    RPT_WAIT = 2'd2
  } rpt_state_e;
endpackage

// File: rtl/ldt_ms_tick.sv
module ldt_ms_tick #(
  parameter int unsigned CLK_PER_MS = 125000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
    end else if (run_i) begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end
  end

  assign tick_o = run_i && !clear_i && (pre_q == PRE_LAST);
endmodule

// File: rtl/ldt_delay_sel.sv
module ldt_delay_sel
  import ldt_pkg::*;
#(
  parameter int unsigned STD_MS          = 750,
  parameter int unsigned FAST_MS [N_FAST] = '{0, 10, 20, 40},
  parameter int unsigned MS_W            = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fast_en_i,
  input  logic [SEL_W-1:0] fast_sel_i,
  output logic             next_zero_o,
  output logic [MS_W-1:0]  held_ms_o
);
  logic [MS_W-1:0] fast_tab [N_FAST];
  logic [MS_W-1:0] next_ms;
  logic [MS_W-1:0] held_q;

  for (genvar g = 0; g < N_FAST; g++) begin : g_tab
    assign fast_tab[g] = MS_W'(FAST_MS[g]);
  end

  assign next_ms     = fast_en_i ? fast_tab[fast_sel_i] : MS_W'(STD_MS);
  assign next_zero_o = (next_ms == '0);

  // target is frozen for the whole failure
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= MS_W'(STD_MS);
    else if (load_i) held_q <= next_ms;
  end

  assign held_ms_o = held_q;
endmodule

// File: rtl/ldt_ms_count.sv
module ldt_ms_count #(
  parameter int unsigned MS_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            tick_i,
  input  logic [MS_W-1:0] target_i,
  output logic            expire_o
);
  logic [MS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // last tick of the window
  assign expire_o = tick_i && (cnt_q == target_i - MS_W'(1));
endmodule

// File: rtl/link_down_timer.sv
module link_down_timer
  import ldt_pkg::*;
#(
  parameter int unsigned CLK_PER_MS       = 125000,
  parameter int unsigned STD_MS           = 750,
  parameter int unsigned FAST_MS [N_FAST] = '{0, 10, 20, 40}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_link_ok_i,
  input  logic             fast_en_i,
  input  logic [SEL_W-1:0] fast_sel_i,
  output logic             link_up_o
);
  localparam int unsigned MS_W = $clog2(STD_MS + FAST_MS[N_FAST-1] + 1);

  rpt_state_e      state_q, state_d;
  logic            load;
  logic            next_zero;
  logic [MS_W-1:0] held_ms;
  logic            tick;
  logic            expire;

  ldt_delay_sel #(
    .STD_MS (STD_MS),
    .FAST_MS(FAST_MS),
    .MS_W   (MS_W)
  ) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .fast_en_i  (fast_en_i),
    .fast_sel_i (fast_sel_i),
    .next_zero_o(next_zero),
    .held_ms_o  (held_ms)
  );

  ldt_ms_tick #(
    .CLK_PER_MS(CLK_PER_MS)
  ) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .run_i  (state_q == RPT_WAIT),
    .tick_o (tick)
  );

  ldt_ms_count #(
    .MS_W(MS_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .tick_i  (tick),
    .target_i(held_ms),
    .expire_o(expire)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      RPT_DOWN: if (raw_link_ok_i) state_d = RPT_UP;
      RPT_UP: begin
        if (!raw_link_ok_i) begin
          load    = 1'b1;
          state_d = next_zero ? RPT_DOWN : RPT_WAIT;
        end
      end
      RPT_WAIT: begin
        if (raw_link_ok_i) state_d = RPT_UP;
        else if (expire)   state_d = RPT_DOWN;
      end
      default: state_d = RPT_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RPT_DOWN;
    else         state_q <= state_d;
  end

  assign link_up_o = (state_q != RPT_DOWN);
endmodule

// File: rtl/ldt_checker.sv
module ldt_checker
  import ldt_pkg::*;
#(
  parameter int unsigned CLK_PER_MS       = 125000,
  parameter int unsigned STD_MS           = 750,
  parameter int unsigned FAST_MS [N_FAST] = '{0, 10, 20, 40}
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             raw_link_ok_i,
  input logic             fast_en_i,
  input logic [SEL_W-1:0] fast_sel_i,
  input logic             link_up_o
);
  logic [31:0] run_cnt;
  logic [31:0] lat_ms;
  logic        fresh_zero;

  assign fresh_zero = fast_en_i && (FAST_MS[fast_sel_i] == 0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt <= '0;
      lat_ms  <= '0;
    end else if (!link_up_o || raw_link_ok_i) begin
      run_cnt <= '0;
    end else begin
      if (run_cnt == '0) lat_ms <= fast_en_i ? 32'(FAST_MS[fast_sel_i]) : 32'(STD_MS);
      run_cnt <= run_cnt + 1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_low: assert (!link_up_o);
    end
  end

  a_r2_link_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_o && raw_link_ok_i |=> link_up_o);

  a_r6_hold_while_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o && raw_link_ok_i |=> link_up_o);

  a_r5_zero_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o && !raw_link_ok_i && (run_cnt == '0) && fresh_zero |=> !link_up_o);

  a_r3_no_early_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o && !raw_link_ok_i && (run_cnt == '0) && !fresh_zero |=> link_up_o);

  a_r4_exact_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_up_o) && ($past(run_cnt) != '0) |->
      $past(run_cnt) == $past(lat_ms) * CLK_PER_MS);

  a_r7_fall_needs_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_up_o) |-> !$past(raw_link_ok_i));
endmodule

bind link_down_timer ldt_checker #(
  .CLK_PER_MS(CLK_PER_MS),
  .STD_MS    (STD_MS),
  .FAST_MS   (FAST_MS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .raw_link_ok_i(raw_link_ok_i),
  .fast_en_i    (fast_en_i),
  .fast_sel_i   (fast_sel_i),
  .link_up_o    (link_up_o)
);

// File: tb/link_down_timer_test.sv
module link_down_timer_test;
  localparam int unsigned DIV   = 4;
  localparam int unsigned N_VEC = 12;
  // {fast_en, sel, low cycles, expect_down}
  localparam logic [19:0] VEC [N_VEC] = '{
    {1'b1, 2'd0, 16'd1,    1'b1},
    {1'b1, 2'd1, 16'd40,   1'b0},
    {1'b1, 2'd1, 16'd41,   1'b1},
    {1'b1, 2'd2, 16'd80,   1'b0},
    {1'b1, 2'd2, 16'd81,   1'b1},
    {1'b1, 2'd3, 16'd160,  1'b0},
    {1'b1, 2'd3, 16'd161,  1'b1},
    {1'b0, 2'd0, 16'd3000, 1'b0},
    {1'b0, 2'd0, 16'd3001, 1'b1},
    {1'b0, 2'd3, 16'd1,    1'b0},
    {1'b0, 2'd1, 16'd50,   1'b0},
    {1'b1, 2'd0, 16'd2,    1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       raw_ok = 1'b1;
  logic       fast_en = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       link_up;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  link_down_timer #(.CLK_PER_MS(DIV)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .raw_link_ok_i(raw_ok),
    .fast_en_i    (fast_en),
    .fast_sel_i   (sel),
    .link_up_o    (link_up)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (link_up !== exp) begin
      n_fail++;
      $display("FAIL %s: link_up_o=%0b expected %0b at %0t", req, link_up, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_vec(input logic fe, input logic [1:0] s, input int len, input logic exp_down);
    raw_ok = 1'b1;
    wait_cyc(2);
    fast_en = fe;
    sel = s;
    raw_ok = 1'b0;
    wait_cyc(len);
    if (fe) check("R4/R5 fast hold boundary", !exp_down);
    else    check("R3 default hold boundary", !exp_down);
    raw_ok = 1'b1;
    wait_cyc(1);
    check("R2/R6 link after recovery", 1'b1);
  endtask

  initial begin
    wait_cyc(3);
    check("R1 reset state", 1'b0);
    rst_ni = 1'b1;
    wait_cyc(1);
    check("R2 rise after reset", 1'b1);

    for (int i = 0; i < N_VEC; i++) begin
      run_vec(VEC[i][19], VEC[i][18:17], int'(VEC[i][16:1]), VEC[i][0]);
    end

    // R7: mode change mid-count keeps the 40 ms target
    raw_ok = 1'b1; wait_cyc(2);
    fast_en = 1'b1; sel = 2'd3; raw_ok = 1'b0;
    wait_cyc(10);
    fast_en = 1'b0; sel = 2'd0;
    wait_cyc(150);
    check("R7 held target survives change", 1'b1);
    wait_cyc(1);
    check("R7 drop at latched 40 ms", 1'b0);
    raw_ok = 1'b1; wait_cyc(1);
    raw_ok = 1'b0; wait_cyc(1);
    check("R7 new setting at next fail", 1'b1);
    raw_ok = 1'b1; wait_cyc(2);

    // R6: restart after a short glitch
    fast_en = 1'b1; sel = 2'd1; raw_ok = 1'b0;
    wait_cyc(30);
    raw_ok = 1'b1; wait_cyc(1);
    raw_ok = 1'b0; wait_cyc(30);
    check("R6 timer restarted", 1'b1);
    wait_cyc(10);
    check("R6 still within new window", 1'b1);
    wait_cyc(1);
    check("R6 drop after full new window", 1'b0);

    // R8: tick idles while up; long up time then 10 ms fail is exact
    raw_ok = 1'b1; wait_cyc(37);
    raw_ok = 1'b0; wait_cyc(40);
    check("R8 tick starts at fail", 1'b1);
    wait_cyc(1);
    check("R8 drop at 10 ms", 1'b0);

    // R1: asynchronous reset while up
    raw_ok = 1'b1; wait_cyc(2);
    check("R2 up before async reset", 1'b1);
    #3 rst_ni = 1'b0;
    #1 check("R1 async reset drop", 1'b0);
    wait_cyc(1);
    rst_ni = 1'b1;
    wait_cyc(1);
    check("R2 rise after second reset", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule